// File: doc/BRIEF.md
# Host Bridge Configuration Function with Window Decoder

This block is the configuration-space function of a processor-bus-to-PCI host bridge, joined to the decoder that tells whether a processor address lies inside a window the bridge forwards to PCI. A register port addressed by dword index reads a small standard header and reads or writes three bridge-private registers: a 32-bit window mask, a 32-bit mode word and a 5-bit read hold-off count. The header fields are fixed: identity, command, class, revision and cache-line size do not change.

The window mask drives the decoder. Its upper bits each open one 256 MB region of the 4 GB space. Its lower sixteen bits each open one 16 MB slice of the topmost 256 MB region. A two-bit bridge-number strap selects the reset contents of the mask and the mode word. At reset the mask opens the 32 MB pair of fine slices owned by this bridge. The hit output is purely combinational from the probe address and the mask currently held in the register.

Top module: `hostbr_window_cfg`

## Requirements
- R1: While reset is held, the window mask (index 16, byte offset 0x40) loads 3 shifted left by twice the 2-bit bridge strap value.
- R2: While reset is held, the mode word (index 17, byte offset 0x44) loads (strap << 2) | 3 and the hold-off register (index 18, byte offset 0x48) loads 8.
- R3: For each mask bit k from 16 to 30 that is set, every address whose top nibble equals k-16 raises window_hit.
- R4: For each mask bit j from 0 to 15 that is set, every address whose top byte equals 0xF0+j raises window_hit.
- R5: Mask bit 31 is stored and read back but opens no window. With the mask all zero, window_hit stays low for every address.
- R6: window_hit follows the address and the registered mask in the same cycle. A mask write shows its effect only from the cycle after the write strobe.
- R7: A write to index 16 or index 17 stores all 32 data bits, and a read of that index returns them.
- R8: A write to index 18 keeps only data bits 4:0. A read of index 18 returns them zero-extended to 32 bits.
- R9: Index 0 reads {DEVICE_ID, VENDOR_ID}. Index 1 reads 0x00000016 (command low half, status zero). Index 3 reads 0x00000008 (cache-line size in bits 7:0). Writes to indices 0 to 15 change nothing.
- R10: Index 2 reads 0x060000 in bits 31:8 and REV_ID in bits 7:0.
- R11: Header indices not named above, and indices 19 to 63, read 0. Writes to indices 19 to 63 leave the mask, the mode and the hold-off unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bridge_id | input | 2 | Bridge-number strap that selects the reset values |
| cfg_wr | input | 1 | Write strobe for the register port |
| cfg_idx | input | 6 | Dword index into the 256-byte configuration space |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Combinational read data for cfg_idx |
| probe_addr | input | 32 | Processor-bus address to be decoded |
| window_hit | output | 1 | High when probe_addr lies in an enabled window |

## Verification
A mask write and a decode of the probe address can fall in the same cycle. In that cycle the decoder must still use the old mask. The bench provokes this by holding an address inside a fine slice that is closed, then raising the write strobe with a mask that opens that slice. It expects window_hit to be low in the write cycle and high in the following cycle. A read of the hold-off index in the same window shows that the register port and the decoder do not disturb each other.

// File: rtl/hostbr_pkg.sv
package hostbr_pkg;

    localparam int DATA_W      = 32;
    localparam int IDX_W       = 6;
    localparam int HDR_DWORDS  = 16;
    localparam int HOLD_W      = 5;
    localparam int COARSE_LO   = 16;
    localparam int COARSE_N    = 15;
    localparam int FINE_N      = 16;
    localparam int DEC_MASK_W  = COARSE_LO + COARSE_N;

    localparam logic [IDX_W-1:0] IDX_WIN_MASK = 6'd16;
    localparam logic [IDX_W-1:0] IDX_MODE     = 6'd17;
    localparam logic [IDX_W-1:0] IDX_HOLD     = 6'd18;

    localparam logic [HOLD_W-1:0] HOLD_RST    = 5'd8;
    localparam logic [15:0]       CMD_FIXED   = 16'h0016;
    localparam logic [7:0]        CLS_FIXED   = 8'h08;
    localparam logic [23:0]       CLASS_FIXED = 24'h060000;
    localparam logic [7:0]        FINE_TOP    = 8'hF0;

    typedef struct packed {
        logic [DATA_W-1:0] win_mask;
        logic [DATA_W-1:0] mode;
        logic [HOLD_W-1:0] hold;
    } vend_regs_t;

    function automatic logic [DATA_W-1:0] rst_mask(input logic [1:0] strap);
        return DATA_W'(32'd3 << {strap, 1'b0});
    endfunction

    function automatic logic [DATA_W-1:0] rst_mode(input logic [1:0] strap);
        return {{(DATA_W-4){1'b0}}, strap, 2'b11};
    endfunction

endpackage

// File: rtl/hostbr_hdr.sv
module hostbr_hdr
    import hostbr_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID = 16'h1A2B,
    parameter logic [15:0] DEVICE_ID = 16'h0003,
    parameter logic [7:0]  REV_ID    = 8'h05
) (
    input  logic [3:0]        hdr_idx,
    output logic [DATA_W-1:0] hdr_rdata
);

    // Fixed header image; writes never reach this module.
    always_comb begin
        case (hdr_idx)
            4'd0:    hdr_rdata = {DEVICE_ID, VENDOR_ID};
            4'd1:    hdr_rdata = {16'h0000, CMD_FIXED};
            4'd2:    hdr_rdata = {CLASS_FIXED, REV_ID};
            4'd3:    hdr_rdata = {24'h000000, CLS_FIXED};
            default: hdr_rdata = '0;
        endcase
    end

endmodule

// File: rtl/hostbr_vregs.sv
module hostbr_vregs
    import hostbr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        strap,
    input  logic              wr,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] win_mask,
    output logic [DATA_W-1:0] vend_rdata
);

    vend_regs_t regs_d, regs_q, regs_rst;

    always_comb begin
        regs_rst.win_mask = rst_mask(strap);
        regs_rst.mode     = rst_mode(strap);
        regs_rst.hold     = HOLD_RST;

        regs_d = regs_q;
        if (wr) begin
            case (idx)
                IDX_WIN_MASK: regs_d.win_mask = wdata;
                IDX_MODE:     regs_d.mode     = wdata;
                IDX_HOLD:     regs_d.hold     = wdata[HOLD_W-1:0];
                default:      ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= regs_rst;
        else        regs_q <= regs_d;
    end

    always_comb begin
        case (idx)
            IDX_WIN_MASK: vend_rdata = regs_q.win_mask;
            IDX_MODE:     vend_rdata = regs_q.mode;
            IDX_HOLD:     vend_rdata = {{(DATA_W-HOLD_W){1'b0}}, regs_q.hold};
            default:      vend_rdata = '0;
        endcase
    end

    assign win_mask = regs_q.win_mask;

    // R1: mask reset value follows the strap
    p_rst_mask_r1: assert property (@(posedge clk)
        !rst_n |=> regs_q.win_mask == (32'd3 << (2 * $past(strap))));

    // R2: mode and hold-off reset values
    p_rst_mode_r2: assert property (@(posedge clk)
        !rst_n |=> (regs_q.mode == {28'd0, $past(strap), 2'b11}) && (regs_q.hold == 5'd8));

    // R7: full-width store of mask and mode
    p_full_store_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && (idx == IDX_WIN_MASK)) |=> regs_q.win_mask == $past(wdata));

    // R8: hold-off keeps only its low bits
    p_hold_trunc_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && (idx == IDX_HOLD)) |=> vend_rdata[DATA_W-1:HOLD_W] == '0 || idx != IDX_HOLD);

    // R11: writes to other indices leave every register untouched
    p_other_wr_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && idx != IDX_WIN_MASK && idx != IDX_MODE && idx != IDX_HOLD)
        |=> $stable(regs_q));

endmodule

// File: rtl/hostbr_windec.sv
module hostbr_windec
    import hostbr_pkg::*;
(
    input  logic [DEC_MASK_W-1:0] dec_mask,
    input  logic [7:0]            addr_top,
    output logic                  hit
);

    logic [COARSE_N-1:0] coarse_match;
    logic [FINE_N-1:0]   fine_match;

    // One comparator per 256 MB region.
    for (genvar i = 0; i < COARSE_N; i++) begin : g_coarse
        assign coarse_match[i] = dec_mask[COARSE_LO + i] && (addr_top[7:4] == 4'(i));
    end

    // One comparator per 16 MB slice of the topmost region.
    for (genvar j = 0; j < FINE_N; j++) begin : g_fine
        assign fine_match[j] = dec_mask[j] && (addr_top == (FINE_TOP + 8'(j)));
    end

    assign hit = (|coarse_match) || (|fine_match);

endmodule

// File: rtl/hostbr_window_cfg.sv
module hostbr_window_cfg
    import hostbr_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID = 16'h1A2B,
    parameter logic [15:0] DEVICE_ID = 16'h0003,
    parameter logic [7:0]  REV_ID    = 8'h05
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  bridge_id,
    input  logic        cfg_wr,
    input  logic [5:0]  cfg_idx,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    input  logic [31:0] probe_addr,
    output logic        window_hit
);

    logic [DATA_W-1:0] hdr_rdata;
    logic [DATA_W-1:0] vend_rdata;
    logic [DATA_W-1:0] win_mask;
    logic [23:0]       unused_addr_low;

    assign unused_addr_low = probe_addr[23:0];

    hostbr_hdr #(
        .VENDOR_ID (VENDOR_ID),
        .DEVICE_ID (DEVICE_ID),
        .REV_ID    (REV_ID)
    ) u_hdr (
        .hdr_idx   (cfg_idx[3:0]),
        .hdr_rdata (hdr_rdata)
    );

    hostbr_vregs u_vregs (
        .clk        (clk),
        .rst_n      (rst_n),
        .strap      (bridge_id),
        .wr         (cfg_wr),
        .idx        (cfg_idx),
        .wdata      (cfg_wdata),
        .win_mask   (win_mask),
        .vend_rdata (vend_rdata)
    );

    hostbr_windec u_dec (
        .dec_mask (win_mask[DEC_MASK_W-1:0]),
        .addr_top (probe_addr[31:24]),
        .hit      (window_hit)
    );

    assign cfg_rdata = (int'(cfg_idx) < HDR_DWORDS) ? hdr_rdata : vend_rdata;

    // R3: an enabled coarse region always hits
    p_coarse_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (probe_addr[31:28] != 4'hF && win_mask[16 + probe_addr[31:28]]) |-> window_hit);

    // R4: an enabled fine slice always hits
    p_fine_hit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (probe_addr[31:28] == 4'hF && win_mask[probe_addr[27:24]]) |-> window_hit);

    // R5: no enabled decode bit means no hit
    p_zero_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (win_mask[30:0] == '0) |-> !window_hit);

    // R6: with address and mask held, hit does not move
    p_hit_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(probe_addr) && $stable(win_mask)) |-> $stable(window_hit));

    // R9: fixed command and cache-line-size dwords
    p_hdr_fixed_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_idx == 6'd1) |-> cfg_rdata == 32'h0000_0016);

    // R10: class and revision dword
    p_class_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_idx == 6'd2) |-> cfg_rdata == {24'h060000, REV_ID});

    // R11: unimplemented vendor indices read zero
    p_unimpl_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_idx > 6'd18) |-> cfg_rdata == 32'h0);

endmodule

// File: tb/test_hostbr_window_cfg.sv
module test_hostbr_window_cfg;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bridge_id = 2'd1;
    logic        cfg_wr = 1'b0;
    logic [5:0]  cfg_idx = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [31:0] probe_addr = '0;
    logic        window_hit;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    // scoreboard queues: kind 0 = read data, kind 1 = hit
    bit          kind_q[$];
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    hostbr_window_cfg i_hostbr_window_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .bridge_id  (bridge_id),
        .cfg_wr     (cfg_wr),
        .cfg_idx    (cfg_idx),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .probe_addr (probe_addr),
        .window_hit (window_hit)
    );

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    // monitor: compare every queued item at the falling edge
    always @(negedge clk) begin
        cycles++;
        while (kind_q.size() > 0) begin
            bit          k;
            logic [31:0] e;
            logic [31:0] a;
            string       t;
            k = kind_q.pop_front();
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            a = k ? {31'd0, window_hit} : cfg_rdata;
            n_checks++;
            if (a !== e) begin
                n_fail++;
                $display("FAIL %s: actual 0x%08h expected 0x%08h", t, a, e);
            end
        end
        if (cycles > 50000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            finish_run();
        end
    end

    task automatic drive(input bit wr, input logic [5:0] idx,
                         input logic [31:0] wd, input logic [31:0] addr);
        @(posedge clk);
        #1;
        cfg_wr     = wr;
        cfg_idx    = idx;
        cfg_wdata  = wd;
        probe_addr = addr;
    endtask

    task automatic exp_rd(input logic [31:0] e, input string t);
        kind_q.push_back(1'b0); exp_q.push_back(e); tag_q.push_back(t);
    endtask

    task automatic exp_hit(input bit e, input string t);
        kind_q.push_back(1'b1); exp_q.push_back({31'd0, e}); tag_q.push_back(t);
    endtask

    task automatic rd(input logic [5:0] idx, input logic [31:0] e, input string t);
        drive(0, idx, '0, 32'h0000_0000);
        exp_rd(e, t);
    endtask

    task automatic wr(input logic [5:0] idx, input logic [31:0] d);
        drive(1, idx, d, 32'h0000_0000);
    endtask

    task automatic probe(input logic [31:0] addr, input bit e, input string t);
        drive(0, 6'd0, '0, addr);
        exp_hit(e, t);
    endtask

    task automatic do_reset(input logic [1:0] s);
        @(posedge clk);
        #1;
        rst_n = 1'b0;
        bridge_id = s;
        cfg_wr = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
    endtask

    initial begin
        // reset with strap 1
        do_reset(2'd1);
        rd(6'd16, 32'h0000_000C, "R1 mask reset strap1");
        rd(6'd17, 32'h0000_0007, "R2 mode reset strap1");
        rd(6'd18, 32'h0000_0008, "R2 holdoff reset");
        probe(32'hF200_0000, 1, "R4 reset slice 2");
        probe(32'hF100_0000, 0, "R4 reset slice 1 closed");

        // reset with strap 3
        do_reset(2'd3);
        rd(6'd16, 32'h0000_00C0, "R1 mask reset strap3");
        rd(6'd17, 32'h0000_000F, "R2 mode reset strap3");
        probe(32'hF6AB_CDEF, 1, "R4 slice 6");
        probe(32'hF7FF_FFFF, 1, "R4 slice 7");
        probe(32'hF5FF_FFFF, 0, "R4 slice 5 closed");
        probe(32'hF800_0000, 0, "R4 slice 8 closed");

        // header
        rd(6'd0, 32'h0003_1A2B, "R9 identity");
        rd(6'd1, 32'h0000_0016, "R9 command");
        rd(6'd2, 32'h0600_0005, "R10 class rev");
        rd(6'd3, 32'h0000_0008, "R9 cache line");
        wr(6'd1, 32'hFFFF_FFFF);
        wr(6'd3, 32'hFFFF_FFFF);
        wr(6'd2, 32'h0000_0000);
        rd(6'd1, 32'h0000_0016, "R9 command write ignored");
        rd(6'd3, 32'h0000_0008, "R9 cache line write ignored");
        rd(6'd2, 32'h0600_0005, "R10 class write ignored");
        rd(6'd5, 32'h0000_0000, "R11 header unused reads 0");
        rd(6'd16, 32'h0000_00C0, "R9 header writes leave mask");

        // coarse windows
        wr(6'd16, 32'h4001_0000);
        rd(6'd16, 32'h4001_0000, "R7 mask readback");
        probe(32'h0ABC_DEF0, 1, "R3 region 0");
        probe(32'h1000_0000, 0, "R3 region 1 closed");
        probe(32'hE123_4567, 1, "R3 region 14");
        probe(32'hF000_0000, 0, "R4 no fine bits");

        // bit 31 decodes nothing
        wr(6'd16, 32'h8000_0000);
        rd(6'd16, 32'h8000_0000, "R5 bit31 stored");
        probe(32'hF000_0000, 0, "R5 bit31 top slice");
        probe(32'hFFFF_FFFF, 0, "R5 bit31 last slice");
        probe(32'h0000_0000, 0, "R5 bit31 region 0");

        // zero mask
        wr(6'd16, 32'h0000_0000);
        probe(32'h0000_0000, 0, "R5 zero mask low");
        probe(32'h7FFF_FFFF, 0, "R5 zero mask mid");
        probe(32'hF300_0000, 0, "R5 zero mask top");

        // same cycle: mask write while probing a closed slice
        drive(1, 6'd16, 32'h0000_0008, 32'hF300_0000);
        exp_hit(0, "R6 old mask in write cycle");
        drive(0, 6'd18, '0, 32'hF300_0000);
        exp_hit(1, "R6 new mask next cycle");
        exp_rd(32'h0000_0008, "R8 holdoff read beside decode");

        // fine edges
        wr(6'd16, 32'h0000_8001);
        probe(32'hF000_0000, 1, "R4 slice 0");
        probe(32'hFFFF_FFFF, 1, "R4 slice 15");
        probe(32'hF100_0000, 0, "R4 slice 1 closed");

        // hold-off and mode
        wr(6'd18, 32'hFFFF_FFE3);
        rd(6'd18, 32'h0000_0003, "R8 holdoff truncation");
        wr(6'd18, 32'h0000_001F);
        rd(6'd18, 32'h0000_001F, "R8 holdoff max");
        wr(6'd17, 32'hDEAD_BEEF);
        rd(6'd17, 32'hDEAD_BEEF, "R7 mode readback");

        // unimplemented vendor indices
        wr(6'd20, 32'hFFFF_FFFF);
        wr(6'd63, 32'h1234_5678);
        rd(6'd20, 32'h0000_0000, "R11 idx20 reads 0");
        rd(6'd63, 32'h0000_0000, "R11 idx63 reads 0");
        rd(6'd16, 32'h0000_8001, "R11 mask unchanged");
        rd(6'd17, 32'hDEAD_BEEF, "R11 mode unchanged");
        rd(6'd18, 32'h0000_001F, "R11 holdoff unchanged");

        drive(0, 6'd0, '0, '0);
        repeat (2) @(posedge clk);
        #1;
        finish_run();
    end

endmodule